// File: doc/BRIEF.md
# CSR Access Permission Checker

This block sits beside a processor's control/status register file and rules, in the same cycle, whether a CSR instruction may proceed or must raise an illegal-instruction exception. It holds no state: every output is a pure function of the instruction's 12-bit register address, the hart's current privilege level, a debug-mode flag, a 32/64-bit base select, a write-intent flag from the decoder and an indication from the register file that the address is implemented.

Access rights come from the address itself. The top two address bits separate read-only registers (both set) from read/write ones, and the next two bits carry the lowest privilege level allowed in. On top of that rule, one sixteen-entry window is reserved to debug mode, and the upper-half counter aliases are reserved whenever the base width is 64 bits. Each kind of violation drives its own bit in a five-bit cause vector; the illegal flag is raised whenever any cause bit is set, and several cause bits may be set together.

The decoder, not this block, decides whether an instruction counts as a write (for example, a set or clear with a zero source does not); this block trusts `wr_intent` as given.

Top module: `csr_perm_check`

## Requirements
- R1: Cause bit 0 (absent) is set exactly when `addr_impl` is low, whatever the other inputs.
- R2: Cause bit 1 (privilege) is set exactly when `cur_priv` is numerically below `csr_addr[9:8]`, with levels encoded User=0, Supervisor=1, Hypervisor=2, Machine=3; Machine mode never sets it.
- R3: Cause bit 2 (read-only write) is set exactly when `csr_addr[11:10]` equals 2'b11 and `wr_intent` is high.
- R4: A read (`wr_intent` low) of any address, and a write to any address whose `csr_addr[11:10]` is 00, 01 or 10, leaves cause bit 2 clear.
- R5: Cause bit 3 (debug-only) is set exactly when `csr_addr` lies in 0x7B0..0x7BF and `dbg_mode` is low, at every privilege level.
- R6: Addresses 0x7A0..0x7AF never set cause bit 3; they follow only the ordinary privilege and read/write rules.
- R7: Cause bit 4 (upper half in 64-bit) is set exactly when `xlen64` is high and `csr_addr` lies in 0xB80..0xB9F or 0xC80..0xC9F; with `xlen64` low it is never set.
- R8: `illegal` is high exactly when at least one cause bit is high; when several violations apply, every matching cause bit is set at once.
- R9: Both outputs settle in the same cycle as the inputs; no clock is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| csr_addr | input | 12 | Register address carried by the CSR instruction |
| cur_priv | input | 2 | Current privilege level (0 User, 1 Supervisor, 2 Hypervisor, 3 Machine) |
| dbg_mode | input | 1 | Hart is in debug mode |
| xlen64 | input | 1 | High selects the 64-bit base, low the 32-bit base |
| wr_intent | input | 1 | Decoder has classed the instruction as writing the register |
| addr_impl | input | 1 | Register file reports the address as implemented |
| illegal | output | 1 | Instruction must raise an illegal-instruction exception |
| cause | output | 5 | Violation vector: [0] absent, [1] privilege, [2] read-only write, [3] debug-only, [4] upper half in 64-bit |

## Verification
The bench builds the checker with its default parameters: a 12-bit address, the debug window at 0x7B0 with sixteen entries and two upper-half windows of thirty-two entries at 0xC80 and 0xB80. With those values the whole input space is 2^18 combinations, so the bench walks every address against every privilege level, debug state, base width, write intent and implemented flag, and compares every cause bit and the illegal flag against a model written from the requirements. That reaches every window edge (0x79F/0x7A0, 0x7AF/0x7B0, 0x7BF/0x7C0, 0xB7F/0xB80, 0xB9F/0xBA0 and the matching 0xC.. edges) and every overlap of violations.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;

    // Privilege encoding: numerically ordered so that "less privileged" is "smaller".
    typedef enum logic [1:0] {
        LVL_USER    = 2'b00,
        LVL_SUPER   = 2'b01,
        LVL_HYPER   = 2'b10,
        LVL_MACHINE = 2'b11
    } lvl_e;

    // Positions of the violation bits in the cause vector.
    localparam int CZ_ABSENT  = 0;
    localparam int CZ_PRIV    = 1;
    localparam int CZ_RO_WR   = 2;
    localparam int CZ_DBGONLY = 3;
    localparam int CZ_UPPER64 = 4;
    localparam int CZ_COUNT   = 5;

    typedef logic [CZ_COUNT-1:0] cause_t;

    // Fields the checker extracts from the address.
    typedef struct packed {
        logic read_only;  // access-class field is all ones
        lvl_e min_lvl;    // lowest level allowed in
    } addr_fields_t;

endpackage

// File: rtl/csr_addr_fields.sv
module csr_addr_fields
    import csr_perm_pkg::*;
#(
    parameter int CSR_AW = 12
) (
    input  logic [CSR_AW-1:0] addr,
    output addr_fields_t      fields
);
    // The access-class field occupies the top two bits, the level field the two below.
    localparam int CLASS_HI = CSR_AW - 1;
    localparam int CLASS_LO = CSR_AW - 2;
    localparam int LVL_HI   = CSR_AW - 3;
    localparam int LVL_LO   = CSR_AW - 4;

    always_comb begin
        fields.read_only = &addr[CLASS_HI:CLASS_LO];
        fields.min_lvl   = lvl_e'(addr[LVL_HI:LVL_LO]);
    end
endmodule

// File: rtl/csr_window_hit.sv
module csr_window_hit #(
    parameter int          CSR_AW = 12,
    parameter logic [31:0] BASE   = 32'h7B0,
    parameter int          SPAN   = 16
) (
    input  logic [CSR_AW-1:0] addr,
    output logic              hit
);
    // One extra bit so that BASE + SPAN cannot wrap at the top of the space.
    localparam int          XW  = CSR_AW + 1;
    localparam logic [XW-1:0] LO_B = XW'(BASE);
    localparam logic [XW-1:0] HI_B = XW'(BASE + 32'(SPAN));

    logic [XW-1:0] ext;

    always_comb begin
        ext = {1'b0, addr};
        hit = (ext >= LO_B) && (ext < HI_B);
    end
endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
    import csr_perm_pkg::*;
#(
    parameter int                       CSR_AW   = 12,
    parameter logic [31:0]              DBG_BASE = 32'h7B0,
    parameter int                       DBG_SPAN = 16,
    parameter int                       UH_COUNT = 2,
    parameter logic [UH_COUNT*32-1:0]   UH_BASES = {32'hB80, 32'hC80},
    parameter int                       UH_SPAN  = 32
) (
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [1:0]        cur_priv,
    input  logic              dbg_mode,
    input  logic              xlen64,
    input  logic              wr_intent,
    input  logic              addr_impl,
    output logic              illegal,
    output logic [4:0]        cause
);
    addr_fields_t          fld;
    logic                  dbg_hit;
    logic [UH_COUNT-1:0]   uh_hit;
    cause_t                cz;

    csr_addr_fields #(.CSR_AW(CSR_AW)) u_fields (
        .addr   (csr_addr),
        .fields (fld)
    );

    csr_window_hit #(.CSR_AW(CSR_AW), .BASE(DBG_BASE), .SPAN(DBG_SPAN)) u_dbg_win (
        .addr (csr_addr),
        .hit  (dbg_hit)
    );

    // One window matcher per reserved upper-half range.
    for (genvar g = 0; g < UH_COUNT; g++) begin : g_uh
        csr_window_hit #(
            .CSR_AW (CSR_AW),
            .BASE   (UH_BASES[g*32 +: 32]),
            .SPAN   (UH_SPAN)
        ) u_uh_win (
            .addr (csr_addr),
            .hit  (uh_hit[g])
        );
    end

    always_comb begin
        cz             = '0;
        cz[CZ_ABSENT]  = !addr_impl;
        cz[CZ_PRIV]    = cur_priv < fld.min_lvl;
        cz[CZ_RO_WR]   = fld.read_only && wr_intent;
        cz[CZ_DBGONLY] = dbg_hit && !dbg_mode;
        cz[CZ_UPPER64] = xlen64 && (|uh_hit);
    end

    assign cause   = cz;
    assign illegal = |cz;

endmodule

// File: rtl/csr_perm_check_sva.sv
module csr_perm_check_sva #(
    parameter int CSR_AW = 12
) (
    input logic [CSR_AW-1:0] csr_addr,
    input logic [1:0]        cur_priv,
    input logic              dbg_mode,
    input logic              xlen64,
    input logic              wr_intent,
    input logic              addr_impl,
    input logic              illegal,
    input logic [4:0]        cause
);
    logic known;
    always_comb known = !$isunknown({csr_addr, cur_priv, dbg_mode, xlen64,
                                     wr_intent, addr_impl, illegal, cause});

    always_comb begin
        if (known) begin
            p_impl_no_absent_r1: assert (!addr_impl || !cause[0]);
            p_machine_no_priv_r2: assert (cur_priv != 2'b11 || !cause[1]);
            p_read_no_ro_r4: assert (wr_intent || !cause[2]);
            p_debug_no_dbgonly_r5: assert (!dbg_mode || !cause[3]);
            p_narrow_no_upper_r7: assert (xlen64 || !cause[4]);
            p_legal_no_cause_r8: assert (illegal || (cause == 5'b0));
            p_cause_forces_illegal_r8: assert (cause == 5'b0 || illegal);
        end
    end
endmodule

bind csr_perm_check csr_perm_check_sva #(.CSR_AW(CSR_AW)) u_sva (
    .csr_addr  (csr_addr),
    .cur_priv  (cur_priv),
    .dbg_mode  (dbg_mode),
    .xlen64    (xlen64),
    .wr_intent (wr_intent),
    .addr_impl (addr_impl),
    .illegal   (illegal),
    .cause     (cause)
);

// File: tb/tb_csr_perm_check.sv
`timescale 1ns/1ps
module tb_csr_perm_check;
    logic        clk = 1'b0;
    logic [11:0] csr_addr;
    logic [1:0]  cur_priv;
    logic        dbg_mode, xlen64, wr_intent, addr_impl;
    logic        illegal;
    logic [4:0]  cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    csr_perm_check dut (
        .csr_addr  (csr_addr),
        .cur_priv  (cur_priv),
        .dbg_mode  (dbg_mode),
        .xlen64    (xlen64),
        .wr_intent (wr_intent),
        .addr_impl (addr_impl),
        .illegal   (illegal),
        .cause     (cause)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h priv=%0d dbg=%0d x64=%0d wr=%0d impl=%0d got=%0b exp=%0b",
                     req, csr_addr, cur_priv, dbg_mode, xlen64, wr_intent, addr_impl, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got=running exp=done");
            finish_run();
        end
    end

    initial begin
        logic e_abs, e_priv, e_ro, e_dbg, e_uh;
        // Idle state: legal machine-mode read of an implemented read/write register.
        csr_addr = 12'h300; cur_priv = 2'd3; dbg_mode = 1'b0;
        xlen64 = 1'b0; wr_intent = 1'b0; addr_impl = 1'b1;
        #3;
        chk("R8 idle illegal", illegal, 1'b0);
        chk("R8 idle cause", |cause, 1'b0);
        #3;
        // Full sweep: drive 1 ns after each clock edge, sample 2 ns later (R9: same cycle).
        for (int v = 0; v < (1 << 18); v++) begin
            csr_addr  = v[11:0];
            cur_priv  = v[13:12];
            dbg_mode  = v[14];
            xlen64    = v[15];
            wr_intent = v[16];
            addr_impl = v[17];
            #2;
            e_abs  = !addr_impl;
            e_priv = int'(cur_priv) < int'(csr_addr[9:8]);
            e_ro   = (csr_addr[11:10] == 2'b11) && wr_intent;
            e_dbg  = (csr_addr >= 12'h7B0) && (csr_addr <= 12'h7BF) && !dbg_mode;
            e_uh   = xlen64 && (((csr_addr >= 12'hC80) && (csr_addr <= 12'hC9F)) ||
                                ((csr_addr >= 12'hB80) && (csr_addr <= 12'hB9F)));
            chk("R1 absent", cause[0], e_abs);
            chk("R2 privilege", cause[1], e_priv);
            chk(e_ro ? "R3 ro write" : "R4 no ro flag", cause[2], e_ro);
            chk((csr_addr[11:4] == 8'h7A) ? "R6 shared debug window" : "R5 debug-only",
                cause[3], e_dbg);
            chk("R7 upper half", cause[4], e_uh);
            chk("R8 illegal", illegal, e_abs | e_priv | e_ro | e_dbg | e_uh);
            #3;
        end
        done = 1'b1;
        finish_run();
    end
endmodule